// File: doc/BRIEF.md
# Sliding-Window Line Write Distributor

This block sits in front of nine 64-bit simple dual-port RAMs that together hold three image lines for a 3×3 sliding window. Each valid clock it accepts a batch of sixteen 8-bit pixels. It steers the batch into one group of three RAMs, with byte-lane write masks, a group write enable and per-RAM address-increment pulses. Each group of three RAMs is treated as one 24-lane row, with lane `j` in RAM `j/8` at byte `j%8`. A batch fills 16 consecutive lanes of that row and wraps from lane 23 to lane 0. Successive lines rotate through the three groups.

Line geometry comes from a small configuration memory, one word per line, that is read asynchronously at `cfg_raddr`. The word is taken at the first batch of a line and held until the line ends. It gives the starting RAM and starting byte lane, the number of batches, the number of pixels in a short final batch, and a flag that closes a frame. Because of this word, a line of any width can start at any lane. The whole write side is computed in one combinational step and then delayed through `LAT` register stages, so data, mask and enables reach the RAM ports in the same cycle.

Configuration word layout, bit 0 first: `[2:0]` lane offset, `[5:3]` start RAM, `[13:6]` batch count minus one, `[14]` frame-close flag, `[18:15]` tail pixel count.

Top module: `winline_writer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid batch reaches the outputs, all write outputs are zero and `cfg_raddr` is 0.
- R2: An input batch appears at the write outputs exactly `LAT` clock cycles after it is accepted. A cycle with `in_vld` low produces all-zero `wr_data`, `wr_mask`, `grp_we`, `addr_inc` and `addr_clr`.
- R3: Pixel `i` of a batch (`in_pix[8i+7:8i]`) lands in lane `(p+i) mod 24` of the active group. On the first batch of a line, `p = (8*start + offset) mod 24`. `p` advances by 16 mod 24 for each further batch of the same line. Group `g` lane `j` is `wr_data[192g+8j +: 8]`.
- R4: `wr_mask[24g+j]` is set exactly for the lanes written in the batch. Data in unwritten lanes is zero.
- R5: A line consists of (batch-count field + 1) valid batches. Cycles with `in_vld` low do not count.
- R6: In the last batch of a line, only pixels `0..tail-1` are written when the tail field is nonzero. A tail field of 0 writes all 16 pixels. All other batches write 16 pixels.
- R7: `addr_inc[3g+k]` pulses for RAM `k` of active group `g` when its lane 7 (group lane `8k+7`) is written. In the last batch of a line it also pulses for any RAM of the group that receives any pixel.
- R8: `grp_we` is one-hot on valid batches. Line 0 after reset uses group 0, and each following line uses the next group modulo 3.
- R9: `cfg_raddr` advances by one after each line's last batch. If that line's frame-close flag is set, `cfg_raddr` returns to 0, the next line uses group 0, and all three `addr_clr` bits pulse with that last batch.
- R10: Configuration fields are taken only at a line's first batch. Changing the word at `cfg_raddr` during the rest of the line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Pixel batch valid |
| in_pix | input | 128 | Sixteen 8-bit pixels, pixel 0 in the low byte |
| cfg_rdata | input | 19 | Configuration word at `cfg_raddr` (asynchronous read) |
| cfg_raddr | output | CFG_AW | Configuration memory read address |
| wr_data | output | 576 | Write data, 192 bits per group |
| wr_mask | output | 72 | Byte-lane write masks, 24 per group |
| grp_we | output | 3 | Group write enables |
| addr_inc | output | 9 | Per-RAM write address increment |
| addr_clr | output | 3 | Per-group write address clear |

## Verification
The bench targets lines that start at lane 23, so that the first pixel sits alone at the top of the row. A design that gets this wrap wrong puts pixels beyond lane 23, or masks the wrong RAM. It also targets single-batch lines with a short tail, and lines whose configuration word is overwritten mid-line. The short tail catches a design that writes full batches or fails to close partly filled words through `addr_inc`. The overwritten word catches a design that re-reads the configuration every cycle, which would then shift lanes halfway through the line. Frame close exposes a design that keeps rotating groups or counting addresses instead of returning to group 0 and address 0. Random idle gaps check that invalid cycles neither advance the batch count nor leak enables.

// File: rtl/swd_pkg.sv
// Shared constants and the configuration word type for the line write distributor.
// Assumes 8-bit pixels, 16-pixel batches and three groups of three 8-lane RAMs.
package swd_pkg;
    localparam int PIX_W        = 8;
    localparam int BATCH        = 16;
    localparam int RAM_LANES    = 8;
    localparam int RAMS_PER_GRP = 3;
    localparam int GROUPS       = 3;
    localparam int GRP_LANES    = RAM_LANES * RAMS_PER_GRP;
    localparam int GRP_DW       = GRP_LANES * PIX_W;
    localparam int IN_W         = BATCH * PIX_W;
    localparam int OUT_DW       = GROUPS * GRP_DW;
    localparam int OUT_MW       = GROUPS * GRP_LANES;
    localparam int NRAMS        = GROUPS * RAMS_PER_GRP;
    localparam int LANE_IW      = $clog2(GRP_LANES);
    localparam int NPIX_W       = $clog2(BATCH + 1);
    localparam int PIX_IW       = $clog2(BATCH);
    localparam int GRP_IW       = $clog2(GROUPS);
    localparam int CFG_W        = 19;

    typedef struct packed {
        logic [3:0] tail;
        logic       fclose;
        logic [7:0] nbatch;
        logic [2:0] start_ram;
        logic [2:0] lane_off;
    } cfg_word_t;
endpackage

// File: rtl/swd_line_tracker.sv
// Tracks position within the current line: lane pointer, remaining batches,
// active group and configuration address. Fields of the configuration word
// are used live on a line's first batch and held for the rest of the line.
// Assumes cfg arrives combinationally for the current cfg_raddr.
module swd_line_tracker
    import swd_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  cfg_word_t         cfg,
    output logic [CFG_AW-1:0] cfg_raddr,
    output logic [LANE_IW-1:0] cur_p,
    output logic [NPIX_W-1:0] n_pix,
    output logic              last,
    output logic              cur_ret,
    output logic [GRP_IW-1:0] grp
);
    logic               fresh_q;
    logic [LANE_IW-1:0] p_q;
    logic [7:0]         cnt_q;
    logic [3:0]         tail_q;
    logic               ret_q;
    logic [GRP_IW-1:0]  grp_q;
    logic [CFG_AW-1:0]  addr_q;

    logic [5:0]         base;
    logic [LANE_IW-1:0] start_p;
    logic [7:0]         cur_cnt;
    logic [3:0]         cur_tail;
    logic [5:0]         sum;
    logic [LANE_IW-1:0] next_p;

    // Select live or held line parameters and derive this batch's geometry.
    always_comb begin
        base     = {cfg.start_ram, 3'b000} + {3'b000, cfg.lane_off};
        start_p  = LANE_IW'(base % 6'(GRP_LANES));
        cur_p    = fresh_q ? start_p : p_q;
        cur_cnt  = fresh_q ? cfg.nbatch : cnt_q;
        cur_tail = fresh_q ? cfg.tail : tail_q;
        cur_ret  = fresh_q ? cfg.fclose : ret_q;
        last     = (cur_cnt == 8'd0);
        n_pix    = (last && cur_tail != 4'd0) ? NPIX_W'(cur_tail) : NPIX_W'(BATCH);
        sum      = {1'b0, cur_p} + 6'(BATCH);
        next_p   = (sum >= 6'(GRP_LANES)) ? LANE_IW'(sum - 6'(GRP_LANES)) : LANE_IW'(sum);
    end

    assign cfg_raddr = addr_q;
    assign grp       = grp_q;

    // Advance line state on each accepted batch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
            p_q     <= '0;
            cnt_q   <= '0;
            tail_q  <= '0;
            ret_q   <= 1'b0;
            grp_q   <= '0;
            addr_q  <= '0;
        end else if (in_vld) begin
            if (last) begin
                fresh_q <= 1'b1;
                addr_q  <= cur_ret ? '0 : addr_q + 1'b1;
                grp_q   <= (cur_ret || grp_q == GRP_IW'(GROUPS - 1)) ? '0 : grp_q + 1'b1;
            end else begin
                fresh_q <= 1'b0;
                p_q     <= next_p;
                cnt_q   <= cur_cnt - 8'd1;
                tail_q  <= cur_tail;
                ret_q   <= cur_ret;
            end
        end
    end
endmodule

// File: rtl/swd_lane_steer.sv
// Rotates a pixel batch into the 24 lanes of one group row and marks the
// written lanes. Pure combinational; assumes n_pix <= BATCH.
module swd_lane_steer
    import swd_pkg::*;
(
    input  logic [IN_W-1:0]      pix,
    input  logic [LANE_IW-1:0]   cur_p,
    input  logic [NPIX_W-1:0]    n_pix,
    output logic [GRP_DW-1:0]    lane_data,
    output logic [GRP_LANES-1:0] lane_mask
);
    logic [PIX_W-1:0] px [BATCH];

    for (genvar i = 0; i < BATCH; i++) begin : g_px
        assign px[i] = pix[i*PIX_W +: PIX_W];
    end

    for (genvar j = 0; j < GRP_LANES; j++) begin : g_lane
        logic [5:0] idx;
        logic       hit;
        // Pixel index landing in lane j, measured from the lane pointer.
        always_comb begin
            if (6'(j) >= {1'b0, cur_p})
                idx = 6'(j) - {1'b0, cur_p};
            else
                idx = 6'(j) + 6'(GRP_LANES) - {1'b0, cur_p};
            hit = (idx < 6'(n_pix));
        end
        assign lane_mask[j] = hit;
        assign lane_data[j*PIX_W +: PIX_W] = hit ? px[idx[PIX_IW-1:0]] : '0;
    end
endmodule

// File: rtl/swd_group_fanout.sv
// Places one group row on the active group's slice and produces enables,
// per-RAM address increments and frame-close clears. Idle cycles give zeros.
module swd_group_fanout
    import swd_pkg::*;
(
    input  logic                 in_vld,
    input  logic [GRP_IW-1:0]    grp,
    input  logic                 last,
    input  logic                 cur_ret,
    input  logic [GRP_DW-1:0]    lane_data,
    input  logic [GRP_LANES-1:0] lane_mask,
    output logic [OUT_DW-1:0]    o_data,
    output logic [OUT_MW-1:0]    o_mask,
    output logic [GROUPS-1:0]    o_we,
    output logic [NRAMS-1:0]     o_inc,
    output logic [GROUPS-1:0]    o_clr
);
    logic [RAMS_PER_GRP-1:0] ram_inc;

    for (genvar k = 0; k < RAMS_PER_GRP; k++) begin : g_ram
        assign ram_inc[k] = lane_mask[k*RAM_LANES + RAM_LANES - 1]
                          | (last & (|lane_mask[k*RAM_LANES +: RAM_LANES]));
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic sel;
        assign sel = in_vld && (grp == GRP_IW'(g));
        assign o_we[g] = sel;
        assign o_data[g*GRP_DW +: GRP_DW] = sel ? lane_data : '0;
        assign o_mask[g*GRP_LANES +: GRP_LANES] = sel ? lane_mask : '0;
        assign o_inc[g*RAMS_PER_GRP +: RAMS_PER_GRP] = sel ? ram_inc : '0;
        assign o_clr[g] = in_vld & last & cur_ret;
    end
endmodule

// File: rtl/swd_delay.sv
// Fixed-latency register pipeline with synchronous clear; DEPTH 0 is a wire.
module swd_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (DEPTH == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] stg [DEPTH];
        // Shift the word one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
            end else begin
                stg[0] <= d;
                for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
            end
        end
        assign q = stg[DEPTH-1];
    end
endmodule

// File: rtl/winline_writer.sv
// Top of the line write distributor: tracks line geometry from a per-line
// configuration word, rotates each batch into the active group and aligns
// all write-side outputs through LAT register stages.
module winline_writer
    import swd_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [IN_W-1:0]   in_pix,
    input  logic [CFG_W-1:0]  cfg_rdata,
    output logic [CFG_AW-1:0] cfg_raddr,
    output logic [OUT_DW-1:0] wr_data,
    output logic [OUT_MW-1:0] wr_mask,
    output logic [GROUPS-1:0] grp_we,
    output logic [NRAMS-1:0]  addr_inc,
    output logic [GROUPS-1:0] addr_clr
);
    localparam int BUS_W = OUT_DW + OUT_MW + GROUPS + NRAMS + GROUPS;

    cfg_word_t            cfg_w;
    logic [LANE_IW-1:0]   cur_p;
    logic [NPIX_W-1:0]    n_pix;
    logic                 last;
    logic                 cur_ret;
    logic [GRP_IW-1:0]    grp;
    logic [GRP_DW-1:0]    lane_data;
    logic [GRP_LANES-1:0] lane_mask;
    logic [OUT_DW-1:0]    c_data;
    logic [OUT_MW-1:0]    c_mask;
    logic [GROUPS-1:0]    c_we;
    logic [NRAMS-1:0]     c_inc;
    logic [GROUPS-1:0]    c_clr;
    logic [BUS_W-1:0]     bus_d;
    logic [BUS_W-1:0]     bus_q;

    assign cfg_w = cfg_word_t'(cfg_rdata);

    swd_line_tracker #(.CFG_AW(CFG_AW)) trk_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cfg(cfg_w),
        .cfg_raddr(cfg_raddr), .cur_p(cur_p), .n_pix(n_pix),
        .last(last), .cur_ret(cur_ret), .grp(grp)
    );

    swd_lane_steer steer_i (
        .pix(in_pix), .cur_p(cur_p), .n_pix(n_pix),
        .lane_data(lane_data), .lane_mask(lane_mask)
    );

    swd_group_fanout fan_i (
        .in_vld(in_vld), .grp(grp), .last(last), .cur_ret(cur_ret),
        .lane_data(lane_data), .lane_mask(lane_mask),
        .o_data(c_data), .o_mask(c_mask), .o_we(c_we),
        .o_inc(c_inc), .o_clr(c_clr)
    );

    assign bus_d = {c_data, c_mask, c_we, c_inc, c_clr};

    swd_delay #(.W(BUS_W), .DEPTH(LAT)) dly_i (
        .clk(clk), .rst_n(rst_n), .d(bus_d), .q(bus_q)
    );

    assign {wr_data, wr_mask, grp_we, addr_inc, addr_clr} = bus_q;
endmodule

// File: rtl/winline_writer_chk.sv
// Protocol checker for the line write distributor, bound to its top.
module winline_writer_chk
    import swd_pkg::*;
#(
    parameter int CFG_AW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_AW-1:0] cfg_raddr,
    input logic [OUT_DW-1:0] wr_data,
    input logic [OUT_MW-1:0] wr_mask,
    input logic [GROUPS-1:0] grp_we,
    input logic [NRAMS-1:0]  addr_inc,
    input logic [GROUPS-1:0] addr_clr
);
    assert_we_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_we));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_we == '0) |-> (wr_mask == '0 && addr_inc == '0 && wr_data == '0 && addr_clr == '0));

    assert_mask_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_we != '0) |-> ($countones(wr_mask) >= 1 && $countones(wr_mask) <= BATCH));

    assert_clr_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(addr_clr) == 0 || $countones(addr_clr) == GROUPS));

    assert_cfg_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr != $past(cfg_raddr)) |->
        (cfg_raddr == CFG_AW'($past(cfg_raddr) + 1'b1) || cfg_raddr == '0));

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assert_mask_in_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_we[g] |-> (wr_mask[g*GRP_LANES +: GRP_LANES] == '0
                            && addr_inc[g*RAMS_PER_GRP +: RAMS_PER_GRP] == '0));
    end

    for (genvar r = 0; r < NRAMS; r++) begin : g_ram
        assert_inc_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
            addr_inc[r] |-> (|wr_mask[r*RAM_LANES +: RAM_LANES]));
    end
endmodule

bind winline_writer winline_writer_chk #(.CFG_AW(CFG_AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_raddr(cfg_raddr), .wr_data(wr_data),
    .wr_mask(wr_mask), .grp_we(grp_we), .addr_inc(addr_inc), .addr_clr(addr_clr)
);

// File: tb/winline_writer_tb_top.sv
`timescale 1ns/1ps
module winline_writer_tb_top;
    localparam int LAT    = 3;
    localparam int CFG_AW = 6;
    localparam int DEPTH  = 1 << CFG_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [127:0]      in_pix = '0;
    logic [18:0]       cfg_rdata;
    logic [CFG_AW-1:0] cfg_raddr;
    logic [575:0]      wr_data;
    logic [71:0]       wr_mask;
    logic [2:0]        grp_we;
    logic [8:0]        addr_inc;
    logic [2:0]        addr_clr;

    logic [18:0] cfg_mem [DEPTH];
    assign cfg_rdata = cfg_mem[cfg_raddr];

    int errors = 0;
    int checks = 0;
    string phase = "R3";

    // Reference state following the requirements
    bit       m_fresh = 1'b1;
    int       m_p = 0, m_cnt = 0, m_tail = 0, m_g = 0, m_addr = 0;
    bit       m_ret = 1'b0;

    logic [575:0] ex_data [LAT];
    logic [71:0]  ex_mask [LAT];
    logic [2:0]   ex_we   [LAT];
    logic [8:0]   ex_inc  [LAT];
    logic [2:0]   ex_clr  [LAT];

    always #4 clk = ~clk;

    winline_writer #(.CFG_AW(CFG_AW), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pix(in_pix),
        .cfg_rdata(cfg_rdata), .cfg_raddr(cfg_raddr), .wr_data(wr_data),
        .wr_mask(wr_mask), .grp_we(grp_we), .addr_inc(addr_inc), .addr_clr(addr_clr)
    );

    task automatic check(input bit ok, input string req, input logic [575:0] act, input logic [575:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    function automatic logic [18:0] mkcfg(input int off, input int st, input int nb, input int fc, input int tl);
        return {4'(tl), 1'(fc), 8'(nb), 3'(st), 3'(off)};
    endfunction

    // Compute expected outputs for one input cycle and advance the reference.
    task automatic model(input logic v, input logic [127:0] pix,
                         output logic [575:0] d, output logic [71:0] m,
                         output logic [2:0] we, output logic [8:0] inc, output logic [2:0] clr);
        logic [18:0] w;
        int p, cnt, tl, n, lane;
        bit rt, lst;
        d = '0; m = '0; we = '0; inc = '0; clr = '0;
        if (!v) return;
        w = cfg_mem[m_addr];
        if (m_fresh) begin
            p = (int'(w[5:3]) * 8 + int'(w[2:0])) % 24;
            cnt = int'(w[13:6]); tl = int'(w[18:15]); rt = w[14];
        end else begin
            p = m_p; cnt = m_cnt; tl = m_tail; rt = m_ret;
        end
        lst = (cnt == 0);
        n = (lst && tl != 0) ? tl : 16;
        for (int i = 0; i < n; i++) begin
            lane = (p + i) % 24;
            d[m_g*192 + lane*8 +: 8] = pix[i*8 +: 8];
            m[m_g*24 + lane] = 1'b1;
        end
        for (int k = 0; k < 3; k++)
            inc[m_g*3 + k] = m[m_g*24 + 8*k + 7] | (lst & (|m[m_g*24 + 8*k +: 8]));
        we[m_g] = 1'b1;
        clr = (lst && rt) ? 3'b111 : 3'b000;
        if (lst) begin
            m_fresh = 1'b1;
            m_addr = rt ? 0 : (m_addr + 1) % DEPTH;
            m_g = rt ? 0 : (m_g + 1) % 3;
        end else begin
            m_fresh = 1'b0; m_p = (p + 16) % 24; m_cnt = cnt - 1; m_tail = tl; m_ret = rt;
        end
    endtask

    // One cycle: compare outputs due now, then drive the next input.
    task automatic step(input logic v, input logic [127:0] pix);
        @(negedge clk);
        if (ex_we[LAT-1] == 3'b000) begin
            check(wr_data == ex_data[LAT-1] && wr_mask == ex_mask[LAT-1] && grp_we == 3'b000
                  && addr_inc == 9'b0 && addr_clr == 3'b0, "R2 idle",
                  {wr_mask, grp_we, addr_inc, addr_clr}, {ex_mask[LAT-1], 3'b0, 9'b0, 3'b0});
        end else begin
            check(wr_data == ex_data[LAT-1], "R3 data", wr_data, ex_data[LAT-1]);
            check(wr_mask == ex_mask[LAT-1], "R4 mask", 576'(wr_mask), 576'(ex_mask[LAT-1]));
            check(grp_we == ex_we[LAT-1], "R8 group enable", 576'(grp_we), 576'(ex_we[LAT-1]));
            check(addr_inc == ex_inc[LAT-1], "R7 addr_inc", 576'(addr_inc), 576'(ex_inc[LAT-1]));
            check(addr_clr == ex_clr[LAT-1], "R9 addr_clr", 576'(addr_clr), 576'(ex_clr[LAT-1]));
        end
        check(int'(cfg_raddr) == m_addr, "R9 cfg_raddr", 576'(cfg_raddr), 576'(m_addr));
        for (int s = LAT - 1; s > 0; s--) begin
            ex_data[s] = ex_data[s-1]; ex_mask[s] = ex_mask[s-1];
            ex_we[s] = ex_we[s-1]; ex_inc[s] = ex_inc[s-1]; ex_clr[s] = ex_clr[s-1];
        end
        model(v, pix, ex_data[0], ex_mask[0], ex_we[0], ex_inc[0], ex_clr[0]);
        in_vld = v;
        in_pix = pix;
    endtask

    function automatic logic [127:0] rpix();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < LAT; s++) begin
            ex_data[s] = '0; ex_mask[s] = '0; ex_we[s] = '0; ex_inc[s] = '0; ex_clr[s] = '0;
        end
        for (int a = 0; a < DEPTH; a++) cfg_mem[a] = mkcfg(0, 0, 1, 0, 0);
        cfg_mem[0] = mkcfg(0, 0, 2, 0, 0);   // three full batches from lane 0
        cfg_mem[1] = mkcfg(7, 2, 1, 0, 0);   // start at lane 23
        cfg_mem[2] = mkcfg(3, 1, 0, 0, 5);   // single short batch
        cfg_mem[3] = mkcfg(5, 0, 4, 0, 9);   // five batches, tail of 9
        cfg_mem[4] = mkcfg(2, 1, 1, 1, 3);   // frame close

        // R1: reset state
        phase = "R1";
        repeat (3) begin
            @(negedge clk);
            check(wr_data == '0 && wr_mask == '0 && grp_we == '0 && addr_inc == '0
                  && addr_clr == '0 && cfg_raddr == '0, "R1 reset",
                  {wr_mask, grp_we, addr_inc, addr_clr}, '0);
        end
        rst_n = 1'b1;

        phase = "R3 lane start 0";
        step(1'b1, rpix()); step(1'b0, '0); step(1'b1, rpix()); step(1'b1, rpix());
        phase = "R3 lane start 23";
        step(1'b1, rpix()); step(1'b1, rpix());
        phase = "R6 single short batch";
        step(1'b1, rpix());
        // R10: change the line's word after its first batch has been taken
        phase = "R10 mid-line cfg change";
        step(1'b1, rpix()); step(1'b1, rpix());
        cfg_mem[3] = mkcfg(1, 2, 0, 1, 2);
        step(1'b1, rpix()); step(1'b0, '0); step(1'b1, rpix()); step(1'b1, rpix());
        phase = "R9 frame close";
        step(1'b1, rpix()); step(1'b1, rpix());
        phase = "R5 idle gaps";
        step(1'b0, '0); step(1'b1, rpix()); step(1'b0, '0); step(1'b1, rpix());

        // Random line geometries and valid patterns
        phase = "R5 random";
        for (int a = 0; a < DEPTH; a++)
            cfg_mem[a] = mkcfg($urandom % 8, $urandom % 8, $urandom % 7,
                               ($urandom % 12) == 0, $urandom % 16);
        for (int c = 0; c < 3000; c++)
            step(($urandom % 4) != 0, rpix());
        for (int c = 0; c < LAT + 2; c++)
            step(1'b0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule